// File: doc/BRIEF.md
# Selectable Clock Post-Divider Bank

This block takes four free-running source clocks and produces four general output clocks plus one side clock. Each general channel picks one of the four sources through its own route setting. It can invert that source. It then divides the result by an integer from a 7-bit setting. Every divide ratio of two or more gives a close to 50% duty cycle, odd ratios included. A setting of zero or one passes the chosen source through unchanged.

Channels A and B each keep two divider settings, bank 0 and bank 1. A 3-bit frequency-select input indexes an 8-bit bank map, and the addressed map bit picks the bank for both channels together. Each channel synchronises that bank bit into its own clock domain. A new divide value, whether from a bank switch or a settings change, takes effect only at the end of the current output period, while the output is low. No shortened pulse appears on the output. The side output always divides source 1 by two, three or four.

Top module: `clk_post_div_bank`

## Requirements
- R1: While `rst_ni` is low, every output (`clk_o` and `clk_e_o`) is held low.
- R2: Channel k (0=A, 1=B, 2=C, 3=D) is clocked from `src_clk_i[route_i[k]]`. Its output period is the period of that source times the divide ratio in force.
- R3: For a divide setting N of 2 or more, the output period is N source periods and the high time is N/2 source periods. For odd N that high time includes a half source period.
- R4: A divide setting of 0 or 1 passes the selected, optionally inverted, source straight to the output.
- R5: A new divide ratio takes effect only at the source edge that ends an output period, with the output low. While the bank switches back and forth, no output high or low phase is shorter than the shorter half-period of the old and new ratios.
- R6: Bit `bank_map_i[freq_sel_i]` picks the bank for both A and B. A 0 selects element [0] of `div_a_i`/`div_b_i` and a 1 selects element [1].
- R7: `clk_e_o` divides `src_clk_i[1]` according to `side_div_i`: 0 gives /2, 1 gives /3, and 2 or 3 give /4.
- R8: When `inv_i[k]` is 1, channel k uses the inverted source. In pass-through mode its output is then low while an uninverted twin on the same source is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | 4 | The four source clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| freq_sel_i | input | 3 | Frequency-select code that indexes the bank map |
| bank_map_i | input | 8 | Bank index for each select code |
| route_i | input | 4x2 | Source number for channels A to D |
| inv_i | input | 4 | Per-channel source inversion |
| div_a_i | input | 2x7 | Channel A divide settings, bank 0 and bank 1 |
| div_b_i | input | 2x7 | Channel B divide settings, bank 0 and bank 1 |
| div_c_i | input | 7 | Channel C divide setting |
| div_d_i | input | 7 | Channel D divide setting |
| side_div_i | input | 2 | Side output ratio code |
| clk_o | output | 4 | Divided clocks for channels A to D |
| clk_e_o | output | 1 | Side clock: source 1 divided by 2, 3 or 4 |

## Verification
The bench measures period and high time on real edges, which exposes a design that sets odd ratios to a 2:1 duty or treats setting zero as a stopped clock. It toggles the bank select repeatedly while it tracks the narrowest pulse on channel A. A divider that swaps ratios mid-period would emit a sliver there. It checks that A and B move to the same bank together, that side code 3 saturates at /4 rather than wrapping, and checks phase at source edges to catch an inversion bit that is ignored or applied to the wrong channel.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
    localparam int unsigned CDB_NUM_SRC  = 4;
    localparam int unsigned CDB_DIV_W    = 7;
    localparam int unsigned CDB_SEL_W    = 3;
    localparam int unsigned CDB_SIDE_W   = 2;
    localparam int unsigned CDB_SIDE_SRC = 1;
    localparam int unsigned CDB_SIDE_MIN = 2;
    localparam int unsigned CDB_SIDE_MAX = 4;
endpackage

// File: rtl/cdb_chan.sv
module cdb_chan #(
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bank_async_i,
    input  logic [DIV_W-1:0] div0_i,
    input  logic [DIV_W-1:0] div1_i,
    output logic             clk_o,
    output logic [DIV_W-1:0] act_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             lvl_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] cur;
        logic             bypass;
        logic             odd;
        logic             rise;
        logic [1:0]       sync;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     half_q;
    logic [DIV_W-1:0] n_sel, n_new, hi_cur;
    logic     last;

    always_comb begin
        n_sel  = st_q.sync[1] ? div1_i : div0_i;
        n_new  = (n_sel == '0) ? DIV_W'(1) : n_sel;
        hi_cur = st_q.cur >> 1;
        last   = (st_q.cnt >= (st_q.cur - DIV_W'(1)));
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], bank_async_i};
        if (last) begin
            // period boundary: output is low here, safe to load the new ratio
            st_d.cnt    = '0;
            st_d.cur    = n_new;
            st_d.bypass = (n_new == DIV_W'(1));
            st_d.odd    = n_new[0];
            st_d.rise   = (n_new != DIV_W'(1));
        end else begin
            st_d.cnt  = st_q.cnt + DIV_W'(1);
            st_d.rise = !st_q.bypass && ((st_q.cnt + DIV_W'(1)) < hi_cur);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt    <= '0;
            st_q.cur    <= DIV_W'(1);
            st_q.bypass <= 1'b0;
            st_q.odd    <= 1'b0;
            st_q.rise   <= 1'b0;
            st_q.sync   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // falling-edge helper stretches the high phase by half a source period
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) half_q <= 1'b0;
        else         half_q <= st_q.rise;
    end

    assign lvl_o  = st_q.rise | (st_q.odd & half_q);
    assign clk_o  = st_q.bypass ? clk_i : lvl_o;
    assign act_o  = st_q.cur;
    assign cnt_o  = st_q.cnt;
    assign wrap_o = last;
endmodule

// File: rtl/clk_post_div_bank.sv
module clk_post_div_bank
    import cdb_pkg::*;
#(
    parameter int unsigned NUM_SRC  = CDB_NUM_SRC,
    parameter int unsigned DIV_W    = CDB_DIV_W,
    parameter int unsigned SEL_W    = CDB_SEL_W,
    parameter int unsigned SIDE_W   = CDB_SIDE_W,
    parameter int unsigned SIDE_SRC = CDB_SIDE_SRC,
    localparam int unsigned SRC_W   = $clog2(NUM_SRC),
    localparam int unsigned MAP_N   = 1 << SEL_W,
    localparam int unsigned NUM_CH  = 4
) (
    input  logic [NUM_SRC-1:0]            src_clk_i,
    input  logic                          rst_ni,
    input  logic [SEL_W-1:0]              freq_sel_i,
    input  logic [MAP_N-1:0]              bank_map_i,
    input  logic [NUM_CH-1:0][SRC_W-1:0]  route_i,
    input  logic [NUM_CH-1:0]             inv_i,
    input  logic [1:0][DIV_W-1:0]         div_a_i,
    input  logic [1:0][DIV_W-1:0]         div_b_i,
    input  logic [DIV_W-1:0]              div_c_i,
    input  logic [DIV_W-1:0]              div_d_i,
    input  logic [SIDE_W-1:0]             side_div_i,
    output logic [NUM_CH-1:0]             clk_o,
    output logic                          clk_e_o
);
    localparam int unsigned NUM_OUT = NUM_CH + 1;

    logic [NUM_OUT-1:0]            ch_clk;
    logic [NUM_OUT-1:0]            div_clk;
    logic [NUM_OUT-1:0]            bank;
    logic [NUM_OUT-1:0]            wrap;
    logic [NUM_OUT-1:0]            lvl;
    logic [NUM_OUT-1:0][DIV_W-1:0] dv0, dv1, act, cnt;
    logic [DIV_W-1:0]              side_n;
    logic                          bank_sel;

    assign bank_sel = bank_map_i[freq_sel_i];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_route
        assign ch_clk[k] = src_clk_i[route_i[k]] ^ inv_i[k];
    end
    assign ch_clk[NUM_CH] = src_clk_i[SIDE_SRC];

    always_comb begin
        side_n = (side_div_i >= SIDE_W'(CDB_SIDE_MAX - CDB_SIDE_MIN))
               ? DIV_W'(CDB_SIDE_MAX)
               : DIV_W'(CDB_SIDE_MIN) + DIV_W'(side_div_i);
        dv0 = {side_n, div_d_i, div_c_i, div_b_i[0], div_a_i[0]};
        dv1 = {side_n, div_d_i, div_c_i, div_b_i[1], div_a_i[1]};
        bank = {3'b000, bank_sel, bank_sel};
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_chan
        cdb_chan #(.DIV_W(DIV_W)) chan_i (
            .clk_i        (ch_clk[k]),
            .rst_ni       (rst_ni),
            .bank_async_i (bank[k]),
            .div0_i       (dv0[k]),
            .div1_i       (dv1[k]),
            .clk_o        (div_clk[k]),
            .act_o        (act[k]),
            .cnt_o        (cnt[k]),
            .wrap_o       (wrap[k]),
            .lvl_o        (lvl[k])
        );
    end

    assign clk_o   = div_clk[NUM_CH-1:0];
    assign clk_e_o = div_clk[NUM_CH];
endmodule

// File: rtl/cdb_chk.sv
module cdb_chk #(
    parameter int unsigned NUM_OUT = 5,
    parameter int unsigned DIV_W   = 7
) (
    input logic                          rst_ni,
    input logic [NUM_OUT-1:0]            ch_clk,
    input logic [NUM_OUT-1:0][DIV_W-1:0] act,
    input logic [NUM_OUT-1:0][DIV_W-1:0] cnt,
    input logic [NUM_OUT-1:0]            wrap,
    input logic [NUM_OUT-1:0]            lvl
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_p
        // R5: the ratio in force only moves after a period boundary
        a_r5_change_on_wrap: assert property (@(posedge ch_clk[k]) disable iff (!rst_ni)
            !wrap[k] |=> $stable(act[k]));
        // R5: the boundary is taken while the divided level is low
        a_r5_low_at_wrap: assert property (@(posedge ch_clk[k]) disable iff (!rst_ni)
            wrap[k] |-> !lvl[k]);
        // R3: the period counter stays below the ratio in force
        a_r3_cnt_bound: assert property (@(posedge ch_clk[k]) disable iff (!rst_ni)
            cnt[k] < act[k]);
    end

    // R7: the side channel always loads a ratio of 2, 3 or 4
    a_r7_side_range: assert property (@(posedge ch_clk[NUM_OUT-1]) disable iff (!rst_ni)
        wrap[NUM_OUT-1] |=> (act[NUM_OUT-1] >= DIV_W'(2) && act[NUM_OUT-1] <= DIV_W'(4)));
endmodule

bind clk_post_div_bank cdb_chk #(.NUM_OUT(NUM_OUT), .DIV_W(DIV_W)) chk_i (
    .rst_ni (rst_ni),
    .ch_clk (ch_clk),
    .act    (act),
    .cnt    (cnt),
    .wrap   (wrap),
    .lvl    (lvl)
);

// File: tb/clk_post_div_bank_tb_top.sv
`timescale 1ns/1ps
module clk_post_div_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P1 = 16;
    localparam int P2 = 6;
    localparam int P3 = 24;

    logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    always #(CLK_PERIOD/2) s0 = ~s0;
    always #(P1/2) s1 = ~s1;
    always #(P2/2) s2 = ~s2;
    always #(P3/2) s3 = ~s3;

    logic [3:0]      src_clk;
    logic            rst_n;
    logic [2:0]      freq_sel;
    logic [7:0]      bank_map;
    logic [3:0][1:0] route;
    logic [3:0]      inv;
    logic [1:0][6:0] div_a, div_b;
    logic [6:0]      div_c, div_d;
    logic [1:0]      side_div;
    logic [3:0]      clk_out;
    logic            clk_e;
    logic [4:0]      outs;

    assign src_clk = {s3, s2, s1, s0};
    assign outs    = {clk_e, clk_out};

    clk_post_div_bank dut_i (
        .src_clk_i(src_clk), .rst_ni(rst_n), .freq_sel_i(freq_sel),
        .bank_map_i(bank_map), .route_i(route), .inv_i(inv),
        .div_a_i(div_a), .div_b_i(div_b), .div_c_i(div_c), .div_d_i(div_d),
        .side_div_i(side_div), .clk_o(clk_out), .clk_e_o(clk_e)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int    ch;
        real   per;
        real   hi;
        string tag;
    } item_t;
    item_t exp_q[$];
    int sent = 0;
    int seen = 0;

    task automatic chk_real(input string tag, input real got, input real exp);
        checks++;
        if (got < exp - 0.01 || got > exp + 0.01) begin
            failures++;
            $display("FAIL %s: got %0.2f expected %0.2f", tag, got, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_clk(input int ch, input real per, input real hi, input string tag);
        item_t it;
        it.ch = ch; it.per = per; it.hi = hi; it.tag = tag;
        exp_q.push_back(it);
        sent++;
        wait (seen == sent);
    endtask

    // monitor: measures the channel named by each expected item
    initial begin
        item_t it;
        real t0, t1, t2;
        forever begin
            wait (exp_q.size() > 0);
            it = exp_q.pop_front();
            wait (outs[it.ch] == 1'b0);
            wait (outs[it.ch] == 1'b1);
            t0 = $realtime;
            wait (outs[it.ch] == 1'b0);
            t1 = $realtime;
            wait (outs[it.ch] == 1'b1);
            t2 = $realtime;
            chk_real({it.tag, " period"}, t2 - t0, it.per);
            chk_real({it.tag, " high"},   t1 - t0, it.hi);
            seen++;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        real min_w, tl;
        rst_n    = 1'b0;
        freq_sel = 3'd0;
        bank_map = 8'b0010_0000;
        route    = {2'd1, 2'd0, 2'd3, 2'd2};
        inv      = 4'b0000;
        div_a    = {7'd5, 7'd3};
        div_b    = {7'd4, 7'd2};
        div_c    = 7'd4;
        div_d    = 7'd7;
        side_div = 2'd0;
        #(CLK_PERIOD * 7 + 1);
        chk_bit("R1 outputs low in reset", |outs, 1'b0);
        #(CLK_PERIOD * 5);
        chk_bit("R1 outputs still low in reset", |outs, 1'b0);
        rst_n = 1'b1;
        #800;
        expect_clk(0, 3.0 * P2, 1.5 * P2, "R3 A odd /3 on src2");
        expect_clk(1, 2.0 * P3, 1.0 * P3, "R6 B bank0 /2 on src3");
        expect_clk(2, 4.0 * CLK_PERIOD, 2.0 * CLK_PERIOD, "R2 C /4 on src0");
        expect_clk(3, 7.0 * P1, 3.5 * P1, "R3 D odd /7 on src1");
        expect_clk(4, 2.0 * P1, 1.0 * P1, "R7 E code0 /2");

        freq_sel = 3'd5;
        #800;
        expect_clk(0, 5.0 * P2, 2.5 * P2, "R6 A bank1 /5");
        expect_clk(1, 4.0 * P3, 2.0 * P3, "R6 B bank1 /4");
        freq_sel = 3'd4;
        #800;
        expect_clk(0, 3.0 * P2, 1.5 * P2, "R6 A map bit4 selects bank0");

        // R5: repeated bank switching must never create a narrow pulse
        min_w = 1.0e9;
        wait (outs[0] == 1'b0);
        @(outs[0]);
        tl = $realtime;
        fork
            begin
                for (int i = 0; i < 8; i++) begin
                    #77;
                    freq_sel = (freq_sel == 3'd4) ? 3'd5 : 3'd4;
                end
            end
            begin
                repeat (50) begin
                    @(outs[0]);
                    if ($realtime - tl < min_w) min_w = $realtime - tl;
                    tl = $realtime;
                end
            end
        join
        chk_real("R5 narrowest pulse while switching", (min_w >= 1.5 * P2 - 0.01) ? 1.0 : min_w, 1.0);

        side_div = 2'd1;
        #400;
        expect_clk(4, 3.0 * P1, 1.5 * P1, "R7 E code1 /3");
        side_div = 2'd2;
        #400;
        expect_clk(4, 4.0 * P1, 2.0 * P1, "R7 E code2 /4");
        side_div = 2'd3;
        #400;
        expect_clk(4, 4.0 * P1, 2.0 * P1, "R7 E code3 saturates at /4");

        div_c = 7'd0;
        div_d = 7'd1;
        route = {2'd0, 2'd0, 2'd3, 2'd0};
        #800;
        expect_clk(2, 1.0 * CLK_PERIOD, 0.5 * CLK_PERIOD, "R4 C setting 0 passes source");
        expect_clk(3, 1.0 * CLK_PERIOD, 0.5 * CLK_PERIOD, "R4 D setting 1 passes source");
        freq_sel = 3'd0;
        #800;
        expect_clk(0, 3.0 * CLK_PERIOD, 1.5 * CLK_PERIOD, "R2 A rerouted to src0");

        wait (outs[2] == 1'b0);
        wait (outs[2] == 1'b1);
        #1;
        chk_bit("R8 D in phase without inversion", outs[3], 1'b1);
        inv = 4'b1000;
        #200;
        wait (outs[2] == 1'b0);
        wait (outs[2] == 1'b1);
        #1;
        chk_bit("R8 D inverted low while C high", outs[3], 1'b0);
        wait (outs[2] == 1'b0);
        #1;
        chk_bit("R8 D inverted high while C low", outs[3], 1'b1);
        chk_bit("R8 C unaffected by D inversion", outs[2], 1'b0);

        finish_run();
    end
endmodule